// File: doc/BRIEF.md
# Serial Host Control Port with Packed Status Readback

This block is the host-side control port of a line transceiver. An external controller frames each access with an active-low chip select. Within that frame it sends two bytes, least significant bit first, on a serial clock. The first byte is a command and the second is a data byte. A write stores the data byte into an eight-bit control register whose bits drive the transceiver's loopback, all-ones transmit, line-code and build-out settings. The same byte carries two bits that clear the change-event flags. A read shifts back the stored byte, but its top three bits are replaced by a three-bit status code. That code merges the active diagnostic modes with sticky flags, which record whether the loss-of-signal or driver-monitor inputs have changed since they were last cleared. While either flag is set, an interrupt output is held high.

All serial inputs are brought into the system clock domain through a two-stage synchronizer. Edges are found there. A state machine walks through the states IDLE, CMD, DATA, DONE and SKIP, using these transitions:

- IDLE to CMD on a chip-select fall.
- CMD to DATA on the eighth rising serial clock when the command matches.
- CMD to SKIP on that edge when the command does not match.
- DATA to DONE on the sixteenth rising serial clock.
- Any active state back to IDLE on a chip-select rise. Only the exit from DONE commits a write.

Top module: `scp_host_port`

## Requirements
- R1: After synchronous reset, ctrl_o is 0, irq is 0 and sdo_oe is 0, and a read returns the byte 8'h00 (status code 000).
- R2: A write uses a command byte with bit 0 = 0, bits 3:1 = 0, bit 4 = 1 and bit 5 = 0, while bits 7:6 are ignored. The bench uses 8'h10 and 8'hD0. The data byte follows, and both bytes are sampled least significant bit first on rising serial-clock edges. After 16 rising edges, ctrl_o takes the data byte once chip select is deasserted.
- R3: If chip select deasserts before the sixteenth rising serial-clock edge, ctrl_o is left unchanged.
- R4: If the command byte breaks the pattern of R2 in bits 5:1, sdo_oe stays 0 for the whole frame and the data byte does not alter ctrl_o.
- R5: A read uses a matching command with bit 0 = 1. The port drives sdo_oe from the first serial-clock fall after the command. It presents the read byte least significant bit first, changing on falling edges, and releases sdo_oe after chip select deasserts. Read-byte bits 4:0 equal ctrl_o bits 4:0, and a read leaves ctrl_o unchanged.
- R6: Read-byte bits 7:5 carry a status code c, placed as bit 5 = c[2], bit 6 = c[1], bit 7 = c[0]. With no event flag set, the code is chosen in this order:
  - remote loopback (ctrl bit 2) gives 100, whatever the other modes;
  - local loopback (bit 3) together with all-ones transmit (bit 4) gives 011;
  - local loopback alone gives 010;
  - all-ones transmit alone gives 001;
  - none of these gives 000.
- R7: A change on los_in sets the LOS flag and a change on dpm_in sets the DPM flag. Any set flag overrides the mode codes of R6: both flags give 111, LOS alone gives 110 and DPM alone gives 101.
- R8: irq is 1 on the clock after a monitor change and stays 1 while either flag is set.
- R9: A committed write with data bit 0 = 1 clears the LOS flag, and one with bit 1 = 1 clears the DPM flag. A flag whose clear bit is 0 stays set, and irq falls only on such a commit.
- R10: If a monitor change is sampled in the same clock as a clearing commit, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial bit clock, idle low |
| sdi | input | 1 | Serial data from host |
| los_in | input | 1 | Loss-of-signal monitor level |
| dpm_in | input | 1 | Driver-performance monitor level |
| sdo | output | 1 | Serial read data (valid while sdo_oe is 1) |
| sdo_oe | output | 1 | Output enable for sdo; 0 means released |
| irq | output | 1 | High while any change flag is set |
| ctrl_o | output | 8 | Stored control byte |

## Verification
A clearing write commit and a monitor change can fall in the same system clock. In that cycle, one function wants to drop a change flag and the other wants to raise it. The bench releases chip select on a known clock and counts the two synchronizer stages and the edge register. It then toggles los_in so that the change is sampled at the exact commit edge. It judges the result by the interrupt staying high and by the next read reporting the LOS code, against a companion run where the same clearing write without a change drops the interrupt.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_DONE,
        ST_SKIP
    } scp_state_e;

    // Status code: event flags first, then modes by priority.
    function automatic logic [2:0] status_code(
        input logic los_f,
        input logic dpm_f,
        input logic rloop,
        input logic lloop,
        input logic ones
    );
        logic [2:0] c;
        if (los_f && dpm_f)     c = 3'b111;
        else if (los_f)         c = 3'b110;
        else if (dpm_f)         c = 3'b101;
        else if (rloop)         c = 3'b100;
        else if (lloop && ones) c = 3'b011;
        else if (lloop)         c = 3'b010;
        else if (ones)          c = 3'b001;
        else                    c = 3'b000;
        return c;
    endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int          N      = 3,
    parameter int          STAGES = 2,
    parameter logic [N-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= {STAGES{INIT[g]}};
            else     pipe <= {pipe[STAGES-2:0], d[g]};
        end
        assign q[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/scp_serial.sv
module scp_serial
    import scp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte
);

    localparam int FRAME  = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(FRAME);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME - 1);

    scp_state_e        state_q, state_d;
    logic              sclk_d, cs_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q, obuf_q, wbyte_q;
    logic              rw_q, drv_q;

    logic sclk_rise, sclk_fall, cs_rise, cs_fall;
    logic [BYTE_W-1:0] next_in;
    logic cmd_ok;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_rise   = cs_n_s & ~cs_d;
    assign cs_fall   = ~cs_n_s & cs_d;
    assign next_in   = {sdi_s, sh_q[BYTE_W-1:1]};
    // Address pattern: bits 3:1 low, bit 4 high, bit 5 low; upper bits free.
    assign cmd_ok    = (next_in[3:1] == 3'b000) && next_in[4] && !next_in[5];

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_fall) state_d = ST_CMD;
            ST_CMD: begin
                if (cs_rise)
                    state_d = ST_IDLE;
                else if (sclk_rise && cnt_q == CMD_LAST)
                    state_d = cmd_ok ? ST_DATA : ST_SKIP;
            end
            ST_DATA: begin
                if (cs_rise)
                    state_d = ST_IDLE;
                else if (sclk_rise && cnt_q == DATA_LAST)
                    state_d = ST_DONE;
            end
            ST_DONE: if (cs_rise) state_d = ST_IDLE;
            ST_SKIP: if (cs_rise) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Edge history and shift datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            cs_d    <= 1'b1;
            cnt_q   <= '0;
            sh_q    <= '0;
            obuf_q  <= '0;
            wbyte_q <= '0;
            rw_q    <= 1'b0;
            drv_q   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_n_s;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
                drv_q <= 1'b0;
            end
            if ((state_q == ST_CMD || state_q == ST_DATA) && sclk_rise) begin
                sh_q  <= next_in;
                cnt_q <= cnt_q + 1'b1;
                if (state_q == ST_CMD && cnt_q == CMD_LAST) begin
                    rw_q   <= next_in[0];
                    obuf_q <= rd_byte;
                end
                if (state_q == ST_DATA && cnt_q == DATA_LAST)
                    wbyte_q <= next_in;
            end
            if ((state_q == ST_DATA || state_q == ST_DONE) && rw_q && sclk_fall) begin
                if (!drv_q) drv_q  <= 1'b1;
                else        obuf_q <= obuf_q >> 1;
            end
        end
    end

    // Outputs
    always_comb begin
        sdo_oe  = drv_q && (state_q == ST_DATA || state_q == ST_DONE);
        sdo     = sdo_oe ? obuf_q[0] : 1'b0;
        wr_stb  = (state_q == ST_DONE) && cs_rise && !rw_q;
        wr_byte = wbyte_q;
    end

endmodule

// File: rtl/scp_regs.sv
module scp_regs
    import scp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              los_in,
    input  logic              dpm_in,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              irq
);

    localparam int B_CLR_LOS = 0;
    localparam int B_CLR_DPM = 1;
    localparam int B_RLOOP   = 2;
    localparam int B_LLOOP   = 3;
    localparam int B_ONES    = 4;
    localparam int B_CODE    = 5;

    logic [BYTE_W-1:0] ctrl_q;
    logic los_q, dpm_q, los_f, dpm_f;
    logic clr_los, clr_dpm;
    logic [2:0] code;

    assign clr_los = wr_stb && wr_byte[B_CLR_LOS];
    assign clr_dpm = wr_stb && wr_byte[B_CLR_DPM];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            los_f  <= 1'b0;
            dpm_f  <= 1'b0;
            los_q  <= los_in;
            dpm_q  <= dpm_in;
        end else begin
            los_q <= los_in;
            dpm_q <= dpm_in;
            if (wr_stb) ctrl_q <= wr_byte;
            // A fresh change wins over a clear in the same cycle.
            los_f <= (los_in != los_q) || (los_f && !clr_los);
            dpm_f <= (dpm_in != dpm_q) || (dpm_f && !clr_dpm);
        end
    end

    always_comb begin
        code    = status_code(los_f, dpm_f, ctrl_q[B_RLOOP],
                              ctrl_q[B_LLOOP], ctrl_q[B_ONES]);
        rd_byte = ctrl_q;
        rd_byte[B_CODE]   = code[2];
        rd_byte[B_CODE+1] = code[1];
        rd_byte[B_CODE+2] = code[0];
        ctrl_o  = ctrl_q;
        irq     = los_f || dpm_f;
    end

endmodule

// File: rtl/scp_host_port.sv
module scp_host_port #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              los_in,
    input  logic              dpm_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              irq,
    output logic [BYTE_W-1:0] ctrl_o
);

    logic [2:0]        sync_q;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_byte, rd_byte;

    scp_sync #(
        .N      (3),
        .STAGES (SYNC_STAGES),
        .INIT   (3'b001)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sdi, sclk, cs_n}),
        .q   (sync_q)
    );

    scp_serial #(.BYTE_W(BYTE_W)) u_serial (
        .clk     (clk),
        .rst     (rst),
        .cs_n_s  (sync_q[0]),
        .sclk_s  (sync_q[1]),
        .sdi_s   (sync_q[2]),
        .rd_byte (rd_byte),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte)
    );

    scp_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .los_in  (los_in),
        .dpm_in  (dpm_in),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte),
        .ctrl_o  (ctrl_o),
        .rd_byte (rd_byte),
        .irq     (irq)
    );

endmodule

// File: rtl/scp_host_port_chk.sv
module scp_host_port_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              los_in,
    input logic              dpm_in,
    input logic              sdo_oe,
    input logic              irq,
    input logic [BYTE_W-1:0] ctrl_o,
    input logic              wr_stb
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_o == '0 && !irq && !sdo_oe));

    assert_commit_deselected_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_o) |-> cs_n);

    assert_drive_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> !cs_n);

    assert_change_raises_irq_R8: assert property (@(posedge clk) disable iff (rst)
        ((los_in != $past(los_in)) || (dpm_in != $past(dpm_in))) |=> irq);

    assert_irq_drop_by_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wr_stb));

endmodule

bind scp_host_port scp_host_port_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .los_in (los_in),
    .dpm_in (dpm_in),
    .sdo_oe (sdo_oe),
    .irq    (irq),
    .ctrl_o (ctrl_o),
    .wr_stb (wr_stb)
);

// File: tb/scp_host_port_test.sv
`timescale 1ns/1ps
module scp_host_port_test;

    localparam int H = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic los_in = 1'b0, dpm_in = 1'b0;
    logic sdo, sdo_oe, irq;
    logic [7:0] ctrl_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    logic [7:0] m_ctrl = 8'h00;
    logic       m_los = 1'b0, m_dpm = 1'b0;
    logic       oe_seen;

    always #2.5 clk = ~clk;

    scp_host_port uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .los_in(los_in), .dpm_in(dpm_in),
        .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq), .ctrl_o(ctrl_o)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] want_read(input logic [7:0] c,
                                             input logic lf, input logic df);
        logic [2:0] k;
        if (lf && df)        k = 3'b111;
        else if (lf)         k = 3'b110;
        else if (df)         k = 3'b101;
        else if (c[2])       k = 3'b100;
        else if (c[3] && c[4]) k = 3'b011;
        else if (c[3])       k = 3'b010;
        else if (c[4])       k = 3'b001;
        else                 k = 3'b000;
        return {k[0], k[1], k[2], c[4:0]};
    endfunction

    // One framed transfer; nbits clocks, optional LOS toggle at the commit clock.
    task automatic xfer(input logic [7:0] cmd, input logic [7:0] data,
                        input int nbits, input bit race,
                        output logic [7:0] rd);
        rd = 8'h00;
        oe_seen = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 8) ? cmd[i] : data[i-8];
            repeat (H) @(negedge clk);
            if (i >= 8) begin
                rd[i-8] = sdo;
                if (sdo_oe) oe_seen = 1'b1;
            end
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        if (race) begin
            @(negedge clk);
            @(negedge clk);
            los_in = ~los_in;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] data);
        logic [7:0] rd;
        xfer(cmd, data, 16, 1'b0, rd);
        m_ctrl = data;
        if (data[0]) m_los = 1'b0;
        if (data[1]) m_dpm = 1'b0;
    endtask

    // Driver side of the scoreboard: push expected, run, hand result to monitor.
    task automatic do_read(input string tag);
        logic [7:0] rd;
        exp_q.push_back(want_read(m_ctrl, m_los, m_dpm));
        tag_q.push_back(tag);
        xfer(8'h11, 8'h00, 16, 1'b0, rd);
        got_q.push_back(rd);
        check(oe_seen, {tag, " R5 sdo_oe driven"}, {7'd0, oe_seen}, 8'h01);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(g == e, t, g, e);
            end
        end
    end

    task automatic toggle(input bit which_los);
        @(negedge clk);
        if (which_los) begin los_in = ~los_in; m_los = 1'b1; end
        else           begin dpm_in = ~dpm_in; m_dpm = 1'b1; end
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        check(ctrl_o == 8'h00, "R1 ctrl_o", ctrl_o, 8'h00);
        check(irq == 1'b0, "R1 irq", {7'd0, irq}, 8'h00);
        check(sdo_oe == 1'b0, "R1 sdo_oe", {7'd0, sdo_oe}, 8'h00);
        do_read("R1 read after reset");

        // R2 write, R6 mode codes
        do_write(8'h10, 8'h04);
        check(ctrl_o == 8'h04, "R2 write rloop", ctrl_o, 8'h04);
        do_read("R6 code rloop");
        do_write(8'h10, 8'hF8);
        check(ctrl_o == 8'hF8, "R2 upper bits stored", ctrl_o, 8'hF8);
        do_read("R6 code lloop+ones");
        do_write(8'h10, 8'h08);
        do_read("R6 code lloop");
        do_write(8'hD0, 8'h10);
        check(ctrl_o == 8'h10, "R2 dont-care cmd bits", ctrl_o, 8'h10);
        do_read("R6 code ones");
        do_write(8'h10, 8'h1C);
        do_read("R6 rloop priority");
        do_write(8'h10, 8'h00);
        do_read("R6 code none");

        // R4 bad command patterns
        do_write(8'h10, 8'h18);
        xfer(8'h12, 8'hFF, 16, 1'b0, rd);
        check(ctrl_o == 8'h18, "R4 bad cmd bit1 ignored", ctrl_o, 8'h18);
        check(!oe_seen, "R4 no drive bit1", {7'd0, oe_seen}, 8'h00);
        xfer(8'h31, 8'h00, 16, 1'b0, rd);
        check(!oe_seen, "R4 no drive bit5 read", {7'd0, oe_seen}, 8'h00);
        xfer(8'h00, 8'h04, 16, 1'b0, rd);
        check(ctrl_o == 8'h18, "R4 bit4 low ignored", ctrl_o, 8'h18);

        // R3 early deselect
        xfer(8'h10, 8'h04, 12, 1'b0, rd);
        check(ctrl_o == 8'h18, "R3 abort keeps ctrl", ctrl_o, 8'h18);
        xfer(8'h10, 8'h04, 15, 1'b0, rd);
        check(ctrl_o == 8'h18, "R3 abort at 15", ctrl_o, 8'h18);

        // R5 read leaves control alone
        do_read("R5 read byte");
        check(ctrl_o == 8'h18, "R5 ctrl after read", ctrl_o, 8'h18);
        check(sdo_oe == 1'b0, "R5 released", {7'd0, sdo_oe}, 8'h00);

        // R7 events, R8 irq, R9 clears
        do_write(8'h10, 8'h04);
        toggle(1'b1);
        check(irq == 1'b1, "R8 irq on los change", {7'd0, irq}, 8'h01);
        do_read("R7 los over rloop");
        toggle(1'b0);
        do_read("R7 both events");
        do_write(8'h10, 8'h04);
        check(irq == 1'b1, "R9 no-clear write keeps irq", {7'd0, irq}, 8'h01);
        do_read("R9 flags sticky");
        do_write(8'h10, 8'h05);
        check(irq == 1'b1, "R8 irq with dpm left", {7'd0, irq}, 8'h01);
        do_read("R7 dpm only after los clear");
        do_write(8'h10, 8'h06);
        check(irq == 1'b0, "R9 irq cleared", {7'd0, irq}, 8'h00);
        do_read("R9 code after clears");

        // R10 change sampled at the clearing commit
        toggle(1'b1);
        xfer(8'h10, 8'h01, 16, 1'b1, rd);
        m_ctrl = 8'h01;
        m_los  = 1'b1;
        check(irq == 1'b1, "R10 set wins over clear", {7'd0, irq}, 8'h01);
        do_read("R10 los code after race");
        do_write(8'h10, 8'h01);
        check(irq == 1'b0, "R9 plain clear", {7'd0, irq}, 8'h00);

        repeat (20) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule